// File: doc/BRIEF.md
# Linear CCD drive clock sequencer

This block makes every digital drive clock for a three-colour linear CCD whose readout registers move charge with two phases. One master clock times everything. A line begins on the rising edge of a trigger. The two-phase clocks first hold still for a setup interval. The transfer gates of all colours then pulse together. The two-phase clocks hold still again for a hold interval. After that they shift the register out pixel by pixel. The reset-gate and clamp pulses run for the whole line, and that includes the time the transfer gate is high. A pixel strobe marks the moment at which a downstream converter may sample each pixel.

The line is built from half-periods of the shift clock, called "halves" here. Each half is `H` master ticks long and carries one pixel. The setup, gate and hold intervals are programmed as whole numbers of halves, so every interval is an exact number of master ticks and the reset and clamp pulses keep one fixed phase for the whole line. All configuration values are captured when a trigger is accepted. A trigger that arrives while a line is running is dropped and raises a sticky overrun flag. Every output comes from a flop, so all outputs lag the internal state by one tick.

Top module: `ccd_clkgen`

## Requirements
- R1: After reset, `phi1` is 1 and every other output is 0. No transfer gate pulse appears before the first trigger.
- R2: An accepted line has four intervals, in this order. Setup lasts S·H ticks, with `phi1`=1 and `phi2`=0. Gate lasts G·H ticks, with the gates high. Hold follows the gate, and `phi1` stays high for (Hd+1)·H ticks after the gate falls: Hd hold halves plus the first shift half. Shift lasts 2·PIX_PAIRS halves.
- R3: All `tgOut` bits are equal at all times.
- R4: In the shift interval, `phi1` is 1 in the first half of each pair and 0 in the second half. It therefore falls exactly PIX_PAIRS times per line. `phi2` is always the complement of `phi1`, and `phiLast` always equals `phi1`.
- R5: While the line is active, `rstGate` goes high for R ticks at the start of every half. That gives S+G+Hd+2·PIX_PAIRS pulses per line, and G of them start while the gate is high.
- R6: `clampOut` rises in the tick in which `rstGate` falls and stays high for C ticks. It is never high at the same time as `rstGate`.
- R7: `pixStrobe` is high for one tick at the last tick of each shift half. That gives 2·PIX_PAIRS strobes per line, and none while the gate is high.
- R8: `lineActive` is high for exactly (S+G+Hd+2·PIX_PAIRS)·H ticks per line. When it falls, `phi1`=1 and `phi2`=0.
- R9: Configuration is sampled only when a trigger is accepted. Changing it during a line has no effect on that line.
- R10: A trigger rising edge during an active line is ignored and sets `overrun`. `overrun` stays set until `ovrClr` is high. If a set and a clear fall in the same tick, the set wins.
- R11: An `H` below 4 is used as 4. An R, C, S, G or Hd of 0 is used as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | master clock |
| rstN | input | 1 | active-low synchronous reset |
| lineTrig | input | 1 | line start; its rising edge is used |
| ovrClr | input | 1 | clears the overrun flag |
| cfgHalfTicks | input | CNT_W | H: master ticks per half |
| cfgRstTicks | input | CNT_W | R: reset-gate pulse width in ticks |
| cfgClampTicks | input | CNT_W | C: clamp pulse width in ticks |
| cfgSetupHalves | input | CNT_W | S: setup interval in halves |
| cfgGateHalves | input | CNT_W | G: gate interval in halves |
| cfgHoldHalves | input | CNT_W | Hd: hold interval in halves |
| phi1 | output | 1 | shift clock phase 1 |
| phi2 | output | 1 | shift clock phase 2 |
| phiLast | output | 1 | last-stage shift clock, in phase with phi1 |
| rstGate | output | 1 | reset gate clock |
| clampOut | output | 1 | reset feed-through clamp clock |
| tgOut | output | NUM_COLORS | per-colour transfer gate |
| lineActive | output | 1 | high while a line runs |
| pixStrobe | output | 1 | converter sample marker |
| overrun | output | 1 | sticky flag for a dropped trigger |

## Verification
If the interval state or the half counter goes wrong, the line changes length at once. The setup, gate or hold tick count at the ports then differs, or the number of `phi1` falls and strobes differs, and the error is visible by the end of that line. If the in-half tick counter or the captured widths go wrong, the reset and clamp widths are off within one half, or a clamp rises without a reset fall just before it. If the overrun flag or the configuration capture goes wrong, the overrun level is wrong on the next tick, or a line changes length when the inputs change part-way through it.

// File: rtl/ccd_clkgen_pkg.sv
package ccd_clkgen_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_GATE,
    ST_HOLD,
    ST_SHIFT
  } lineState_t;

  // Strobes from the sequencer to the clock datapath
  typedef struct packed {
    logic lineGo;    // trigger accepted this tick
    logic active;    // a line is running
    logic gateOn;    // transfer gate window
    logic shifting;  // two-phase clocks toggle
    logic oddHalf;   // second half of a pixel pair
  } seqStrobe_t;

endpackage

// File: rtl/ccd_clkgen_ctrl.sv
module ccd_clkgen_ctrl
  import ccd_clkgen_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int PIX_PAIRS = 2569
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lineTrig,
  input  logic             ovrClr,
  input  logic [CNT_W-1:0] cfgSetupHalves,
  input  logic [CNT_W-1:0] cfgGateHalves,
  input  logic [CNT_W-1:0] cfgHoldHalves,
  input  logic             halfEnd,
  output seqStrobe_t       seq,
  output logic             overrun
);

  localparam int LINE_HALVES = 2 * PIX_PAIRS;
  localparam int HALF_W      = $clog2(LINE_HALVES + 1);
  localparam int SEG_W       = (HALF_W > CNT_W) ? HALF_W : CNT_W;

  lineState_t       st;
  logic [SEG_W-1:0] seg;
  logic [SEG_W-1:0] segLim;
  logic [CNT_W-1:0] setupLim, gateLim, holdLim;
  logic             trigPrev;
  logic             trigRise;
  logic             goNow;
  logic             segLast;

  assign trigRise = lineTrig && !trigPrev;
  assign goNow    = trigRise && (st == ST_IDLE);

  always_comb begin
    case (st)
      ST_SETUP: segLim = SEG_W'(setupLim);
      ST_GATE:  segLim = SEG_W'(gateLim);
      ST_HOLD:  segLim = SEG_W'(holdLim);
      ST_SHIFT: segLim = SEG_W'(LINE_HALVES);
      default:  segLim = SEG_W'(1);
    endcase
  end

  assign segLast = (seg == segLim - 1'b1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st       <= ST_IDLE;
      seg      <= '0;
      setupLim <= CNT_W'(1);
      gateLim  <= CNT_W'(1);
      holdLim  <= CNT_W'(1);
      trigPrev <= 1'b0;
    end else begin
      trigPrev <= lineTrig;
      if (goNow) begin
        st       <= ST_SETUP;
        seg      <= '0;
        setupLim <= (cfgSetupHalves == '0) ? CNT_W'(1) : cfgSetupHalves;
        gateLim  <= (cfgGateHalves  == '0) ? CNT_W'(1) : cfgGateHalves;
        holdLim  <= (cfgHoldHalves  == '0) ? CNT_W'(1) : cfgHoldHalves;
      end else if (halfEnd && st != ST_IDLE) begin
        if (segLast) begin
          seg <= '0;
          case (st)
            ST_SETUP: st <= ST_GATE;
            ST_GATE:  st <= ST_HOLD;
            ST_HOLD:  st <= ST_SHIFT;
            default:  st <= ST_IDLE;
          endcase
        end else begin
          seg <= seg + 1'b1;
        end
      end
    end
  end

  // Sticky overrun: a busy trigger sets it, and a set beats a clear
  always_ff @(posedge clk) begin
    if (!rstN)                        overrun <= 1'b0;
    else if (trigRise && st != ST_IDLE) overrun <= 1'b1;
    else if (ovrClr)                  overrun <= 1'b0;
  end

  always_comb begin
    seq.lineGo   = goNow;
    seq.active   = (st != ST_IDLE);
    seq.gateOn   = (st == ST_GATE);
    seq.shifting = (st == ST_SHIFT);
    seq.oddHalf  = seg[0];
  end

  a_r10_overrun_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overrun && !ovrClr |=> overrun);

  a_r10_busy_trigger_sets: assert property (@(posedge clk) disable iff (!rstN)
    trigRise && seq.active |=> overrun);

  a_r2_go_enters_setup: assert property (@(posedge clk) disable iff (!rstN)
    seq.lineGo |=> (st == ST_SETUP) && (seg == '0));

  a_r2_seg_in_range: assert property (@(posedge clk) disable iff (!rstN)
    seq.active |-> (seg < segLim));

endmodule

// File: rtl/ccd_clkgen_dp.sv
module ccd_clkgen_dp
  import ccd_clkgen_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int NUM_COLORS = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  seqStrobe_t            seq,
  input  logic [CNT_W-1:0]      cfgHalfTicks,
  input  logic [CNT_W-1:0]      cfgRstTicks,
  input  logic [CNT_W-1:0]      cfgClampTicks,
  output logic                  halfEnd,
  output logic                  phi1,
  output logic                  phi2,
  output logic                  phiLast,
  output logic                  rstGate,
  output logic                  clampOut,
  output logic [NUM_COLORS-1:0] tgOut,
  output logic                  lineActive,
  output logic                  pixStrobe
);

  localparam logic [CNT_W-1:0] MIN_HALF = CNT_W'(4);

  logic [CNT_W-1:0] ph;
  logic [CNT_W-1:0] halfLim, rstLim, clLim;
  logic [CNT_W:0]   clEnd;
  logic             rstNext, clNext, phi1Next;

  assign halfEnd = seq.active && (ph == halfLim - 1'b1);
  assign clEnd   = {1'b0, rstLim} + {1'b0, clLim};

  // Widths captured at line start only
  always_ff @(posedge clk) begin
    if (!rstN) begin
      halfLim <= MIN_HALF;
      rstLim  <= CNT_W'(1);
      clLim   <= CNT_W'(1);
    end else if (seq.lineGo) begin
      halfLim <= (cfgHalfTicks < MIN_HALF) ? MIN_HALF : cfgHalfTicks;
      rstLim  <= (cfgRstTicks   == '0) ? CNT_W'(1) : cfgRstTicks;
      clLim   <= (cfgClampTicks == '0) ? CNT_W'(1) : cfgClampTicks;
    end
  end

  // Tick position within the current half
  always_ff @(posedge clk) begin
    if (!rstN)              ph <= '0;
    else if (seq.lineGo)    ph <= '0;
    else if (halfEnd)       ph <= '0;
    else if (seq.active)    ph <= ph + 1'b1;
  end

  assign rstNext  = seq.active && (ph < rstLim);
  assign clNext   = seq.active && (ph >= rstLim) && ({1'b0, ph} < clEnd);
  assign phi1Next = !(seq.shifting && seq.oddHalf);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phi1       <= 1'b1;
      phi2       <= 1'b0;
      phiLast    <= 1'b0;
      rstGate    <= 1'b0;
      clampOut   <= 1'b0;
      lineActive <= 1'b0;
      pixStrobe  <= 1'b0;
    end else begin
      phi1       <= phi1Next;
      phi2       <= !phi1Next;
      phiLast    <= phi1Next;
      rstGate    <= rstNext;
      clampOut   <= clNext;
      lineActive <= seq.active;
      pixStrobe  <= seq.shifting && halfEnd;
    end
  end

  for (genvar g = 0; g < NUM_COLORS; g++) begin : g_gate
    logic tgQ;
    always_ff @(posedge clk) begin
      if (!rstN) tgQ <= 1'b0;
      else       tgQ <= seq.gateOn;
    end
    assign tgOut[g] = tgQ;
  end

  // R4: the two phases are complementary from reset onwards
  a_r4_phase_complement: assert property (@(posedge clk) disable iff (!rstN)
    phi1 != phi2);

  // R4: after the first clocked cycle the last stage tracks phi1
  a_r4_last_in_phase: assert property (@(posedge clk) disable iff (!rstN)
    lineActive |-> (phiLast == phi1));

  a_r2_gate_phases_still: assert property (@(posedge clk) disable iff (!rstN)
    tgOut[0] |-> phi1 && !phi2 && $stable(phi1));

  a_r3_gates_equal: assert property (@(posedge clk) disable iff (!rstN)
    tgOut == {NUM_COLORS{tgOut[0]}});

  a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    !(rstGate && clampOut));

  a_r6_clamp_follows: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clampOut) |-> $fell(rstGate));

  a_r7_strobe_in_shift: assert property (@(posedge clk) disable iff (!rstN)
    pixStrobe |-> lineActive && !tgOut[0]);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !lineActive |-> !rstGate && !clampOut && !pixStrobe && !tgOut[0]);

endmodule

// File: rtl/ccd_clkgen.sv
module ccd_clkgen
  import ccd_clkgen_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int PIX_PAIRS  = 2569,
  parameter int NUM_COLORS = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  lineTrig,
  input  logic                  ovrClr,
  input  logic [CNT_W-1:0]      cfgHalfTicks,
  input  logic [CNT_W-1:0]      cfgRstTicks,
  input  logic [CNT_W-1:0]      cfgClampTicks,
  input  logic [CNT_W-1:0]      cfgSetupHalves,
  input  logic [CNT_W-1:0]      cfgGateHalves,
  input  logic [CNT_W-1:0]      cfgHoldHalves,
  output logic                  phi1,
  output logic                  phi2,
  output logic                  phiLast,
  output logic                  rstGate,
  output logic                  clampOut,
  output logic [NUM_COLORS-1:0] tgOut,
  output logic                  lineActive,
  output logic                  pixStrobe,
  output logic                  overrun
);

  seqStrobe_t seq;
  logic       halfEnd;

  ccd_clkgen_ctrl #(
    .CNT_W     (CNT_W),
    .PIX_PAIRS (PIX_PAIRS)
  ) i_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .lineTrig       (lineTrig),
    .ovrClr         (ovrClr),
    .cfgSetupHalves (cfgSetupHalves),
    .cfgGateHalves  (cfgGateHalves),
    .cfgHoldHalves  (cfgHoldHalves),
    .halfEnd        (halfEnd),
    .seq            (seq),
    .overrun        (overrun)
  );

  ccd_clkgen_dp #(
    .CNT_W      (CNT_W),
    .NUM_COLORS (NUM_COLORS)
  ) i_dp (
    .clk           (clk),
    .rstN          (rstN),
    .seq           (seq),
    .cfgHalfTicks  (cfgHalfTicks),
    .cfgRstTicks   (cfgRstTicks),
    .cfgClampTicks (cfgClampTicks),
    .halfEnd       (halfEnd),
    .phi1          (phi1),
    .phi2          (phi2),
    .phiLast       (phiLast),
    .rstGate       (rstGate),
    .clampOut      (clampOut),
    .tgOut         (tgOut),
    .lineActive    (lineActive),
    .pixStrobe     (pixStrobe)
  );

endmodule

// File: tb/test_ccd_clkgen.sv
module test_ccd_clkgen;

  localparam int CLK_PERIOD = 10;
  localparam int CW   = 8;
  localparam int NP   = 6;
  localparam int NC   = 3;
  localparam int WDOG = 150000;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          lineTrig = 1'b0;
  logic          ovrClr = 1'b0;
  logic [CW-1:0] cfgHalfTicks = '0, cfgRstTicks = '0, cfgClampTicks = '0;
  logic [CW-1:0] cfgSetupHalves = '0, cfgGateHalves = '0, cfgHoldHalves = '0;
  logic          phi1, phi2, phiLast, rstGate, clampOut, lineActive, pixStrobe, overrun;
  logic [NC-1:0] tgOut;

  always #(CLK_PERIOD/2) clk = ~clk;

  ccd_clkgen #(.CNT_W(CW), .PIX_PAIRS(NP), .NUM_COLORS(NC)) i_ccd_clkgen (
    .clk(clk), .rstN(rstN), .lineTrig(lineTrig), .ovrClr(ovrClr),
    .cfgHalfTicks(cfgHalfTicks), .cfgRstTicks(cfgRstTicks), .cfgClampTicks(cfgClampTicks),
    .cfgSetupHalves(cfgSetupHalves), .cfgGateHalves(cfgGateHalves), .cfgHoldHalves(cfgHoldHalves),
    .phi1(phi1), .phi2(phi2), .phiLast(phiLast), .rstGate(rstGate), .clampOut(clampOut),
    .tgOut(tgOut), .lineActive(lineActive), .pixStrobe(pixStrobe), .overrun(overrun)
  );

  typedef struct {
    int h; int r; int c; int s; int g; int hd;
  } lineExp_t;

  lineExp_t expQ[$];
  int nChecks = 0;
  int nBad = 0;
  int linesDone = 0;
  bit finished = 0;

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finishUp();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  endtask

  // Driver: program, push the expected line (R11 clamping), pulse the trigger
  task automatic startLine(input int h, input int r, input int c,
                           input int s, input int g, input int hd);
    lineExp_t e;
    @(negedge clk);
    cfgHalfTicks = CW'(h); cfgRstTicks = CW'(r); cfgClampTicks = CW'(c);
    cfgSetupHalves = CW'(s); cfgGateHalves = CW'(g); cfgHoldHalves = CW'(hd);
    e.h = (h < 4) ? 4 : h; e.r = (r == 0) ? 1 : r; e.c = (c == 0) ? 1 : c;
    e.s = (s == 0) ? 1 : s; e.g = (g == 0) ? 1 : g; e.hd = (hd == 0) ? 1 : hd;
    expQ.push_back(e);
    lineTrig = 1'b1;
    @(negedge clk);
    lineTrig = 1'b0;
  endtask

  task automatic waitLineEnd(input int startCount);
    while (linesDone == startCount) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // Monitor state
  bit  pAct = 0, pRst = 0, pCl = 0, pPhi1 = 1;
  bit  gateSeen, shiftSeen;
  int  actCnt, setupCnt, gateCnt, holdCnt, falls, strobes, rstRises, rstInGate;
  int  rstW, clW, rstWErr, clWErr, followErr, strobeInGate, setupPhiErr, complErr, tgErr;

  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (lineActive && !pAct) begin
        gateSeen = 0; shiftSeen = 0;
        actCnt = 0; setupCnt = 0; gateCnt = 0; holdCnt = 0; falls = 0; strobes = 0;
        rstRises = 0; rstInGate = 0; rstW = 0; clW = 0; rstWErr = 0; clWErr = 0;
        followErr = 0; strobeInGate = 0; setupPhiErr = 0; complErr = 0; tgErr = 0;
      end
      if (phi1 == phi2) complErr++;
      if (lineActive && phiLast != phi1) complErr++;
      if (tgOut != {NC{tgOut[0]}}) tgErr++;
      if (lineActive && expQ.size() > 0) begin
        actCnt++;
        if (tgOut[0]) begin gateSeen = 1; gateCnt++; end
        if (!gateSeen) begin
          setupCnt++;
          if (!phi1 || phi2) setupPhiErr++;
        end
        if (pPhi1 && !phi1) begin falls++; shiftSeen = 1; end
        if (gateSeen && !tgOut[0] && !shiftSeen) holdCnt++;
        if (rstGate && !pRst) begin rstRises++; if (tgOut[0]) rstInGate++; end
        if (rstGate) rstW++;
        if (!rstGate && pRst) begin if (rstW != expQ[0].r) rstWErr++; rstW = 0; end
        if (clampOut && !pCl && !(pRst && !rstGate)) followErr++;
        if (clampOut) clW++;
        if (!clampOut && pCl) begin if (clW != expQ[0].c) clWErr++; clW = 0; end
        if (pixStrobe) begin strobes++; if (tgOut[0]) strobeInGate++; end
      end
      if (!lineActive && pAct && expQ.size() > 0) begin
        lineExp_t e;
        e = expQ.pop_front();
        check("R2 setup ticks", setupCnt, e.s * e.h);
        check("R2 setup phases still", setupPhiErr, 0);
        check("R2 gate ticks", gateCnt, e.g * e.h);
        check("R2 hold ticks", holdCnt, (e.hd + 1) * e.h);
        check("R3 gate bits equal", tgErr, 0);
        check("R4 phi1 falls", falls, NP);
        check("R4 complement", complErr, 0);
        check("R5 reset pulses", rstRises, e.s + e.g + e.hd + 2 * NP);
        check("R5 reset pulses in gate", rstInGate, e.g);
        check("R5 reset width", rstWErr, 0);
        check("R6 clamp width", clWErr, 0);
        check("R6 clamp follows reset", followErr, 0);
        check("R7 strobes", strobes, 2 * NP);
        check("R7 strobe in gate", strobeInGate, 0);
        check("R8 active ticks", actCnt, (e.s + e.g + e.hd + 2 * NP) * e.h);
        check("R8 idle phi1", int'(phi1), 1);
        check("R8 idle phi2", int'(phi2), 0);
        linesDone++;
      end
      pAct = lineActive; pRst = rstGate; pCl = clampOut; pPhi1 = phi1;
    end
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    nChecks++; nBad++;
    $display("FAIL watchdog actual=%0d expected=0", WDOG);
    finishUp();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state, and no gate without a trigger
    n = 0;
    repeat (20) begin
      @(negedge clk);
      if (tgOut != '0 || lineActive || rstGate || clampOut || pixStrobe || phi2 || !phi1 || overrun) n++;
    end
    check("R1 reset quiet", n, 0);
    check("R1 phi1 high", int'(phi1), 1);

    // Line A: basic sequence
    startLine(8, 2, 3, 2, 3, 2);
    waitLineEnd(0);

    // Line B: R9 mid-line reconfig ignored, R10 busy trigger flagged
    startLine(10, 3, 4, 1, 5, 1);
    repeat (30) @(negedge clk);
    cfgHalfTicks = 8'd20; cfgSetupHalves = 8'd7; cfgRstTicks = 8'd9; cfgGateHalves = 8'd2;
    lineTrig = 1'b1; @(negedge clk); lineTrig = 1'b0;
    @(negedge clk);
    check("R10 overrun set", int'(overrun), 1);
    waitLineEnd(1);
    check("R10 overrun sticky", int'(overrun), 1);
    check("R10 extra line not started", int'(lineActive), 0);
    ovrClr = 1'b1; @(negedge clk); ovrClr = 1'b0; @(negedge clk);
    check("R10 overrun cleared", int'(overrun), 0);

    // Line C: R11 clamping of too-small values
    startLine(2, 0, 0, 0, 0, 0);
    waitLineEnd(2);

    // Line D: wide pulses, set beats clear
    startLine(12, 5, 6, 3, 2, 4);
    repeat (20) @(negedge clk);
    lineTrig = 1'b1; ovrClr = 1'b1; @(negedge clk); lineTrig = 1'b0; ovrClr = 1'b0;
    @(negedge clk);
    check("R10 set wins over clear", int'(overrun), 1);
    waitLineEnd(3);
    check("R9 all lines seen", linesDone, 4);
    finishUp();
  end

endmodule